// File: doc/BRIEF.md
# Outer Bank Register File with Write Lockout

This block is the set of five outer banking registers that sit next to an MMC3-style mapper core in a cartridge mapper. The CPU writes them through a 4 KiB address window. A board strap picks where that window sits: $6000-$6FFF when the strap is low, $5000-$5FFF when it is high. Inside the window, only address bits 15:12 and 2:0 are decoded (mask $F007). This means each register appears many times across the window. When the window sits on top of work RAM, the register file only watches the writes. It does not claim them, so the RAM behind it still sees every write.

Every bit of every register is brought out as a named field. Downstream logic uses these fields to form outer PRG and CHR address bits, pick the bit sources, and select the GNROM-style and "weird" MMC3 modes. There are two write-protection rules. First, a lockout bit freezes all registers except the CHR GNROM register. The lockout acts only while GNROM mode is off. Second, a lock bit inside the CHR GNROM register freezes that register's upper nibble. A reset clears every register. Nothing but a reset can undo a lockout that is taken in MMC3 mode.

Top module: `outer_bank_regs`

## Requirements
- R1: A write takes effect only if (cpuAddr AND $F007) equals the window base with bits 2:0 giving register index 0 to 4. Address bits 11:3 are ignored, so for example $6FF8 reaches register 0. Writes with index 5, 6 or 7, and writes outside the window, change no register.
- R2: When windowSel is 0 the window base is $6000. When windowSel is 1 the window base is $5000.
- R3: Register 0 uses these bit positions: bits 2:0 go to prgOuterLo (A19..A17), bit 3 to chrAltA17, bits 5:4 to prgOuterHi (A24:A23), bit 6 to prgA17FromOuter, and bit 7 to chrA17FromAlt.
- R4: Register 1 uses these bit positions: bit 0 goes to sc0 and bit 1 to gnPrg32k. prgOuterMid is {A22,A21,A20} and takes A20 from bit 4, A22 from bit 3 and A21 from bit 2. Bit 5 goes to prgA20FromCore, bit 6 to prgA19FromCore, and bit 7 to prgA18FromOuter.
- R5: Register 2 uses these bit positions: bits 3:0 go to gnChrBank, bits 6:4 to chrMask, and bit 7 to chrMaskLock. While chrMaskLock is 1, a write to register 2 updates only bits 3:0.
- R6: Register 3 uses these bit positions: bit 0 goes to sc1, bits 3:1 to gnPrgBank (A16..A14), bit 4 to gnromMode, bit 5 to wramLowEn, bit 6 to weirdMode, and bit 7 to lockout.
- R7: While lockout is 1 and gnromMode is 0, writes to registers 0, 1, 3 and 4 are ignored. Register 2 can still be written, under the rule of R5.
- R8: While gnromMode is 1, the lockout bit has no effect and every register can be written.
- R9: Register 4 uses these bit positions: bit 0 goes to mixedChrEn and bits 7:1 to chrRamMatch.
- R10: An active-low reset clears all registers to zero. An accepted write shows on the outputs after the clock edge on which cpuWrite is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| windowSel | input | 1 | Window strap: 0 selects $6xxx, 1 selects $5xxx |
| cpuWrite | input | 1 | Single-cycle CPU write strobe |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| prgOuterLo | output | 3 | PRG outer A19..A17 |
| chrAltA17 | output | 1 | Alternate CHR A17 |
| prgOuterHi | output | 2 | PRG outer A24:A23 |
| prgA17FromOuter | output | 1 | PRG A17 source (1 = outer) |
| chrA17FromAlt | output | 1 | CHR A17 source (1 = alternate) |
| sc0 | output | 1 | Size-control bit 0 |
| gnPrg32k | output | 1 | GNROM PRG bank is 32 KiB |
| prgOuterMid | output | 3 | PRG outer {A22,A21,A20} |
| prgA20FromCore | output | 1 | PRG A20 source (1 = core) |
| prgA19FromCore | output | 1 | PRG A19 source (1 = core) |
| prgA18FromOuter | output | 1 | PRG A18 source (1 = outer) |
| gnChrBank | output | 4 | GNROM CHR A16..A13 |
| chrMask | output | 3 | GNROM CHR bitmask |
| chrMaskLock | output | 1 | Freezes chrMask and chrMaskLock |
| sc1 | output | 1 | Size-control bit 1 |
| gnPrgBank | output | 3 | GNROM PRG A16..A14 |
| gnromMode | output | 1 | GNROM mode enable |
| wramLowEn | output | 1 | Also enable PRG RAM at $5000 |
| weirdMode | output | 1 | Weird MMC3 mode |
| lockout | output | 1 | Register write lockout |
| mixedChrEn | output | 1 | Mixed CHR-ROM/RAM enable |
| chrRamMatch | output | 7 | Bank value selecting CHR-RAM |

## Verification
The block's state is its output fields, so a wrong internal state shows at the ports on the first cycle after the faulty write, with no further delay. A decode fault can show in two ways: a register changes after a write to a mirror-miss or index 5-7 address, or it stays unchanged after a write that should have landed. A fault in the lock logic shows only after lockout or chrMaskLock has been set. For that reason the stimulus resets often and exercises the lock rules both with GNROM mode on and with it off. Every write is followed by a comparison of all five reconstructed register bytes against a bench model, so a fault is seen on the next write at the latest.

// File: rtl/outer_bank_pkg.sv
package outer_bank_pkg;
  localparam int REG_COUNT = 5;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 16;
  localparam int IDX_W     = 3;
  localparam logic [ADDR_W-1:0] DECODE_MASK = 16'hF007;
  localparam logic [3:0] WIN_HI_LOW_STRAP  = 4'h6;
  localparam logic [3:0] WIN_HI_HIGH_STRAP = 4'h5;
  localparam int CHR_GN_REG = 2;

  typedef struct packed {
    logic [REG_COUNT-1:0] wrEn;
    logic                 keepChrHi;
  } regStrobe_t;
endpackage

// File: rtl/outer_bank_ctrl.sv
module outer_bank_ctrl
  import outer_bank_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEC_MASK = DECODE_MASK,
  parameter logic [3:0] WIN_LOW  = WIN_HI_LOW_STRAP,
  parameter logic [3:0] WIN_HIGH = WIN_HI_HIGH_STRAP
) (
  input  logic              cpuWrite,
  input  logic              windowSel,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              lockoutBit,
  input  logic              gnromBit,
  input  logic              chrLockBit,
  output regStrobe_t        strobe
);
  localparam int HI_LSB = ADDR_W - 4;

  logic [ADDR_W-1:0] maskedAddr;
  logic [3:0]        winHi;
  logic              inWindow;
  logic              frozen;
  logic [IDX_W-1:0]  regIdx;

  always_comb begin
    maskedAddr = cpuAddr & DEC_MASK;
    winHi      = windowSel ? WIN_HIGH : WIN_LOW;
    inWindow   = (maskedAddr[ADDR_W-1:HI_LSB] == winHi)
               && (maskedAddr[HI_LSB-1:IDX_W] == '0);
    regIdx     = maskedAddr[IDX_W-1:0];
    frozen     = lockoutBit && !gnromBit;
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_strobe
    if (i == CHR_GN_REG) begin : g_exempt
      assign strobe.wrEn[i] = cpuWrite && inWindow && (regIdx == IDX_W'(i));
    end else begin : g_lockable
      assign strobe.wrEn[i] = cpuWrite && inWindow && (regIdx == IDX_W'(i)) && !frozen;
    end
  end

  assign strobe.keepChrHi = chrLockBit;
endmodule

// File: rtl/outer_bank_dp.sv
module outer_bank_dp
  import outer_bank_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [DATA_W-1:0]                  cpuData,
  input  regStrobe_t                         strobe,
  output logic [REG_COUNT-1:0][DATA_W-1:0]   regFile
);
  localparam int HALF = DATA_W / 2;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    if (i == CHR_GN_REG) begin : g_partial
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= '0;
        end else if (strobe.wrEn[i]) begin
          if (strobe.keepChrHi) q <= {q[DATA_W-1:HALF], cpuData[HALF-1:0]};
          else                  q <= cpuData;
        end
      end
    end else begin : g_full
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               q <= '0;
        else if (strobe.wrEn[i]) q <= cpuData;
      end
    end
    assign regFile[i] = q;
  end
endmodule

// File: rtl/outer_bank_regs.sv
module outer_bank_regs
  import outer_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        windowSel,
  input  logic        cpuWrite,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuData,
  output logic [2:0]  prgOuterLo,
  output logic        chrAltA17,
  output logic [1:0]  prgOuterHi,
  output logic        prgA17FromOuter,
  output logic        chrA17FromAlt,
  output logic        sc0,
  output logic        gnPrg32k,
  output logic [2:0]  prgOuterMid,
  output logic        prgA20FromCore,
  output logic        prgA19FromCore,
  output logic        prgA18FromOuter,
  output logic [3:0]  gnChrBank,
  output logic [2:0]  chrMask,
  output logic        chrMaskLock,
  output logic        sc1,
  output logic [2:0]  gnPrgBank,
  output logic        gnromMode,
  output logic        wramLowEn,
  output logic        weirdMode,
  output logic        lockout,
  output logic        mixedChrEn,
  output logic [6:0]  chrRamMatch
);
  regStrobe_t strobe;
  logic [REG_COUNT-1:0][DATA_W-1:0] regFile;

  outer_bank_ctrl u_ctrl (
    .cpuWrite   (cpuWrite),
    .windowSel  (windowSel),
    .cpuAddr    (cpuAddr),
    .lockoutBit (regFile[3][7]),
    .gnromBit   (regFile[3][4]),
    .chrLockBit (regFile[2][7]),
    .strobe     (strobe)
  );

  outer_bank_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cpuData (cpuData),
    .strobe  (strobe),
    .regFile (regFile)
  );

  assign prgOuterLo      = regFile[0][2:0];
  assign chrAltA17       = regFile[0][3];
  assign prgOuterHi      = regFile[0][5:4];
  assign prgA17FromOuter = regFile[0][6];
  assign chrA17FromAlt   = regFile[0][7];

  assign sc0             = regFile[1][0];
  assign gnPrg32k        = regFile[1][1];
  assign prgOuterMid     = {regFile[1][3], regFile[1][2], regFile[1][4]};
  assign prgA20FromCore  = regFile[1][5];
  assign prgA19FromCore  = regFile[1][6];
  assign prgA18FromOuter = regFile[1][7];

  assign gnChrBank       = regFile[2][3:0];
  assign chrMask         = regFile[2][6:4];
  assign chrMaskLock     = regFile[2][7];

  assign sc1             = regFile[3][0];
  assign gnPrgBank       = regFile[3][3:1];
  assign gnromMode       = regFile[3][4];
  assign wramLowEn       = regFile[3][5];
  assign weirdMode       = regFile[3][6];
  assign lockout         = regFile[3][7];

  assign mixedChrEn      = regFile[4][0];
  assign chrRamMatch     = regFile[4][7:1];
endmodule

// File: rtl/outer_bank_regs_chk.sv
module outer_bank_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        windowSel,
  input logic        cpuWrite,
  input logic [15:0] cpuAddr,
  input logic [7:0]  cpuData,
  input logic [2:0]  prgOuterLo,
  input logic        chrAltA17,
  input logic [1:0]  prgOuterHi,
  input logic        prgA17FromOuter,
  input logic        chrA17FromAlt,
  input logic        sc0,
  input logic        gnPrg32k,
  input logic [2:0]  prgOuterMid,
  input logic        prgA20FromCore,
  input logic        prgA19FromCore,
  input logic        prgA18FromOuter,
  input logic [3:0]  gnChrBank,
  input logic [2:0]  chrMask,
  input logic        chrMaskLock,
  input logic        sc1,
  input logic [2:0]  gnPrgBank,
  input logic        gnromMode,
  input logic        wramLowEn,
  input logic        weirdMode,
  input logic        lockout,
  input logic        mixedChrEn,
  input logic [6:0]  chrRamMatch
);
  logic [7:0] b0, b1, b2, b3, b4;
  logic       hit;
  logic [2:0] idx;

  assign b0  = {chrA17FromAlt, prgA17FromOuter, prgOuterHi, chrAltA17, prgOuterLo};
  assign b1  = {prgA18FromOuter, prgA19FromCore, prgA20FromCore,
                prgOuterMid[0], prgOuterMid[2], prgOuterMid[1], gnPrg32k, sc0};
  assign b2  = {chrMaskLock, chrMask, gnChrBank};
  assign b3  = {lockout, weirdMode, wramLowEn, gnromMode, gnPrgBank, sc1};
  assign b4  = {chrRamMatch, mixedChrEn};
  assign idx = cpuAddr[2:0];
  assign hit = cpuWrite && (cpuAddr[15:12] == (windowSel ? 4'h5 : 4'h6)) && (idx < 3'd5);

  AST_MISS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> $stable({b0, b1, b2, b3, b4})); // R1

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (lockout && !gnromMode && !(hit && idx == 3'd2)) |=> $stable({b0, b1, b3, b4})); // R7

  AST_CHR_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    chrMaskLock |=> $stable(b2[7:4])); // R5

  AST_REG0_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (hit && idx == 3'd0 && (!lockout || gnromMode)) |=> (b0 == $past(cpuData))); // R3

  AST_GN_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (hit && idx == 3'd4 && lockout && gnromMode) |=> (b4 == $past(cpuData))); // R8
endmodule

bind outer_bank_regs outer_bank_regs_chk u_chk (.*);

// File: tb/outer_bank_regs_tb.sv
`timescale 1ns/1ps
module outer_bank_regs_tb;
  logic clk = 0, rstN = 0, windowSel = 0, cpuWrite = 0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic [2:0] prgOuterLo, prgOuterMid, chrMask, gnPrgBank;
  logic [1:0] prgOuterHi;
  logic [3:0] gnChrBank;
  logic [6:0] chrRamMatch;
  logic chrAltA17, prgA17FromOuter, chrA17FromAlt, sc0, gnPrg32k, prgA20FromCore,
        prgA19FromCore, prgA18FromOuter, chrMaskLock, sc1, gnromMode, wramLowEn,
        weirdMode, lockout, mixedChrEn;

  int checks = 0, errors = 0;
  logic [7:0] expReg [5];

  always #4 clk = ~clk;

  outer_bank_regs u_dut (.*);

  function automatic logic [7:0] obs(int i);
    case (i)
      0: return {chrA17FromAlt, prgA17FromOuter, prgOuterHi, chrAltA17, prgOuterLo};
      1: return {prgA18FromOuter, prgA19FromCore, prgA20FromCore,
                 prgOuterMid[0], prgOuterMid[2], prgOuterMid[1], gnPrg32k, sc0};
      2: return {chrMaskLock, chrMask, gnChrBank};
      3: return {lockout, weirdMode, wramLowEn, gnromMode, gnPrgBank, sc1};
      default: return {chrRamMatch, mixedChrEn};
    endcase
  endfunction

  function automatic string regReq(int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic checkAll(string tag);
    for (int i = 0; i < 5; i++) begin
      checks++;
      if (obs(i) !== expReg[i]) begin
        errors++;
        $display("FAIL %s/%s reg%0d actual=%02h expected=%02h", tag, regReq(i), i, obs(i), expReg[i]);
      end
    end
  endtask

  task automatic modelWrite(logic [15:0] a, logic [7:0] d);
    logic [15:0] m = a & 16'hF007;
    logic [3:0] hi = windowSel ? 4'h5 : 4'h6;
    int idx = int'(m[2:0]);
    if (m[15:12] == hi && m[11:3] == 0 && idx < 5) begin
      if (expReg[3][7] && !expReg[3][4] && idx != 2) return;
      if (idx == 2 && expReg[2][7]) expReg[2] = {expReg[2][7:4], d[3:0]};
      else expReg[idx] = d;
    end
  endtask

  task automatic doWrite(logic [15:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWrite = 1;
    @(negedge clk);
    cpuWrite = 0;
    modelWrite(a, d);
    checkAll(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) expReg[i] = 8'h00;
    checkAll("R10");
    rstN = 1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0268));
    doReset();
    // R3 R4 R5 R6 R9 with low strap (R2)
    windowSel = 0;
    doWrite(16'h6000, 8'hA5, "R3");
    doWrite(16'h6001, 8'h5A, "R4");
    doWrite(16'h6002, 8'h6C, "R5");
    doWrite(16'h6003, 8'h7B, "R6");
    doWrite(16'h6004, 8'hD3, "R9");
    // R1: unused indices, other window, mirror
    doWrite(16'h6005, 8'hFF, "R1");
    doWrite(16'h6007, 8'hFF, "R1");
    doWrite(16'h7000, 8'hFF, "R1");
    doWrite(16'h6FF8, 8'h3C, "R1");
    // R2: high strap
    windowSel = 1;
    doWrite(16'h6000, 8'h11, "R2");
    doWrite(16'h5001, 8'h22, "R2");
    // R5 lock
    doWrite(16'h5002, 8'h9A, "R5");
    doWrite(16'h5002, 8'h65, "R5");
    // R7 lockout
    doWrite(16'h5003, 8'h80, "R7");
    doWrite(16'h5000, 8'hFF, "R7");
    doWrite(16'h5002, 8'h03, "R7");
    doWrite(16'h5003, 8'h90, "R7");
    doWrite(16'h5004, 8'hEE, "R7");
    // R8 GNROM bypass
    doReset();
    doWrite(16'h5003, 8'h90, "R8");
    doWrite(16'h5000, 8'h77, "R8");
    doWrite(16'h5004, 8'h12, "R8");
    doWrite(16'h5003, 8'h80, "R8");
    doWrite(16'h5004, 8'h34, "R7");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] a;
      logic [3:0] hi;
      int sel;
      if (n % 40 == 0) begin
        windowSel = 1'($urandom);
        doReset();
      end
      hi = windowSel ? 4'h5 : 4'h6;
      sel = int'($urandom % 8);
      a = 16'($urandom);
      if (sel < 5)       a = {hi, 9'h000, 3'($urandom)};
      else if (sel == 5) a = {hi, a[11:0]};
      else if (sel == 6) a = {(windowSel ? 4'h6 : 4'h5), a[11:0]};
      doWrite(a, 8'($urandom), "R1/R7/R8");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule